// File: doc/BRIEF.md
# High-Half Byte Insert, Extract and Mask Unit

This unit is a 64-bit integer execution slice. It handles the "high" forms of the byte-field instructions. The slice receives a 7-bit function code, a source operand A and a position operand B. Only the three lowest bits of B matter: they name a byte lane from 0 to 7. The slice then does one of three things to A:

- it moves a 16, 32 or 64-bit field of A into the upper part of a register image (insert-high);
- it pulls such a field back down (extract-high);
- it clears the lanes of A that a field starting at that lane would spill past the top of the register (mask-high).

Insert-high and extract-high share one complemented shift count, computed in bits as (64 − 8·lane) mod 64. Insert-high truncates A to the field width first and then shifts right. Extract-high shifts A left first and then truncates to the field width. If the function code is not one of the nine the slice knows, the result is the old destination value, which arrives on its own input. The destination is therefore left as it was.

The result is computed combinationally and captured in a register on a valid strobe. It appears one clock after the strobe. A two-state output sequencer tracks whether the register holds a fresh result:

- OS_EMPTY moves to OS_FULL when a strobe is sampled.
- OS_FULL stays in OS_FULL on a back-to-back strobe.
- Either state goes to OS_EMPTY when no strobe is sampled, or when reset is applied.

The output-valid flag is high in OS_FULL.

Top module: `bxm_high_unit`

## Requirements
- R1: Function codes 0x57, 0x67 and 0x77 select insert-high for 16, 32 and 64-bit fields. The result is (A truncated to the field width) shifted right logically by (64 − 8·B[2:0]) mod 64.
- R2: Function codes 0x5A, 0x6A and 0x7A select extract-high for 16, 32 and 64-bit fields. The result is A shifted left logically by (64 − 8·B[2:0]) mod 64, then truncated to the field width and zero-extended.
- R3: Function codes 0x52, 0x62 and 0x72 select mask-high, with lane masks 0x3, 0xF and 0xFF for the 16, 32 and 64-bit fields. The lane mask is shifted right by 8 − B[2:0]. Bit k of the shifted mask set means byte k of A (bits 8k+7 down to 8k) is cleared; every other byte passes unchanged.
- R4: A lane of zero gives a shift of zero for insert-high and extract-high. For mask-high, a lane of zero returns A unchanged.
- R5: Bits 63 down to 3 of B have no effect on the result.
- R6: Any other function code yields the old-destination input as the result.
- R7: A result captured on a strobe appears on the result port, with output-valid high, exactly one clock later. Output-valid is low in a cycle that follows a clock edge without a strobe.
- R8: The result port holds its value across clock edges without a strobe, whatever the other inputs do.
- R9: A synchronous reset clears the result to zero and output-valid to low. Reset wins over a strobe in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation strobe |
| func | input | 7 | Function code |
| src_a | input | 64 | Source operand A |
| src_b | input | 64 | Position operand; bits 2:0 give the byte lane |
| dst_old | input | 64 | Current destination value, returned for unknown codes |
| out_valid | output | 1 | Result is fresh (sequencer in OS_FULL) |
| result | output | 64 | Registered result |

## Verification
Two events can land on the same clock edge: a strobe that would load a new result, and a synchronous reset that clears the register. The bench raises in_valid with live operands in every reset cycle, both at start-up and in the middle of traffic. It judges the following cycle against a zero result with output-valid low. A second pairing is also exercised: a hold cycle directly after a load, with operands changing while the strobe is low. The result must keep the loaded value.

// File: rtl/bxm_pkg.sv
package bxm_pkg;

    typedef enum logic [1:0] {
        OPK_NONE = 2'd0,
        OPK_INS  = 2'd1,
        OPK_EXT  = 2'd2,
        OPK_MSK  = 2'd3
    } op_kind_e;

    typedef enum logic [1:0] {
        WD_WORD = 2'd0,
        WD_LONG = 2'd1,
        WD_QUAD = 2'd2
    } op_width_e;

    typedef struct packed {
        op_kind_e  kind;
        op_width_e width;
    } op_sel_t;

    typedef enum logic {
        OS_EMPTY = 1'b0,
        OS_FULL  = 1'b1
    } out_state_e;

    localparam int FUNC_W = 7;

    localparam logic [FUNC_W-1:0] FN_INS_W = 7'h57;
    localparam logic [FUNC_W-1:0] FN_INS_L = 7'h67;
    localparam logic [FUNC_W-1:0] FN_INS_Q = 7'h77;
    localparam logic [FUNC_W-1:0] FN_EXT_W = 7'h5A;
    localparam logic [FUNC_W-1:0] FN_EXT_L = 7'h6A;
    localparam logic [FUNC_W-1:0] FN_EXT_Q = 7'h7A;
    localparam logic [FUNC_W-1:0] FN_MSK_W = 7'h52;
    localparam logic [FUNC_W-1:0] FN_MSK_L = 7'h62;
    localparam logic [FUNC_W-1:0] FN_MSK_Q = 7'h72;

endpackage

// File: rtl/bxm_decode.sv
module bxm_decode
    import bxm_pkg::*;
(
    input  logic [FUNC_W-1:0] func,
    output op_sel_t           sel
);

    always_comb begin
        sel = '{kind: OPK_NONE, width: WD_QUAD};
        unique case (func)
            FN_INS_W: sel = '{kind: OPK_INS, width: WD_WORD};
            FN_INS_L: sel = '{kind: OPK_INS, width: WD_LONG};
            FN_INS_Q: sel = '{kind: OPK_INS, width: WD_QUAD};
            FN_EXT_W: sel = '{kind: OPK_EXT, width: WD_WORD};
            FN_EXT_L: sel = '{kind: OPK_EXT, width: WD_LONG};
            FN_EXT_Q: sel = '{kind: OPK_EXT, width: WD_QUAD};
            FN_MSK_W: sel = '{kind: OPK_MSK, width: WD_WORD};
            FN_MSK_L: sel = '{kind: OPK_MSK, width: WD_LONG};
            FN_MSK_Q: sel = '{kind: OPK_MSK, width: WD_QUAD};
            default:  sel = '{kind: OPK_NONE, width: WD_QUAD};
        endcase
    end

endmodule

// File: rtl/bxm_hishift.sv
module bxm_hishift
    import bxm_pkg::*;
#(
    parameter int DATA_W = 64,
    localparam int NBYTES = DATA_W / 8,
    localparam int OFS_W  = $clog2(NBYTES),
    localparam int SH_W   = OFS_W + 3
) (
    input  op_width_e         width,
    input  logic [DATA_W-1:0] data_in,
    input  logic [OFS_W-1:0]  lane,
    output logic [DATA_W-1:0] ins_out,
    output logic [DATA_W-1:0] ext_out
);

    localparam logic [DATA_W-1:0] FMASK_W = {{(DATA_W-16){1'b0}}, {16{1'b1}}};
    localparam logic [DATA_W-1:0] FMASK_L = {{(DATA_W-32){1'b0}}, {32{1'b1}}};
    localparam logic [DATA_W-1:0] FMASK_Q = {DATA_W{1'b1}};

    logic [DATA_W-1:0] fmask;
    logic [SH_W-1:0]   shamt;

    always_comb begin
        unique case (width)
            WD_WORD: fmask = FMASK_W;
            WD_LONG: fmask = FMASK_L;
            WD_QUAD: fmask = FMASK_Q;
            default: fmask = FMASK_Q;
        endcase
    end

    // complemented byte shift, wraps to zero for lane 0
    assign shamt   = SH_W'(0) - {lane, 3'b000};
    assign ins_out = (data_in & fmask) >> shamt;
    assign ext_out = (data_in << shamt) & fmask;

endmodule

// File: rtl/bxm_himask.sv
module bxm_himask
    import bxm_pkg::*;
#(
    parameter int DATA_W = 64,
    localparam int NBYTES = DATA_W / 8,
    localparam int OFS_W  = $clog2(NBYTES),
    localparam int AMT_W  = OFS_W + 1
) (
    input  op_width_e         width,
    input  logic [DATA_W-1:0] data_in,
    input  logic [OFS_W-1:0]  lane,
    output logic [DATA_W-1:0] data_out
);

    localparam logic [NBYTES-1:0] LMASK_W = NBYTES'(2'b11);
    localparam logic [NBYTES-1:0] LMASK_L = NBYTES'(4'hF);
    localparam logic [NBYTES-1:0] LMASK_Q = {NBYTES{1'b1}};

    logic [NBYTES-1:0] lmask;
    logic [NBYTES-1:0] kill;
    logic [AMT_W-1:0]  amt;

    always_comb begin
        unique case (width)
            WD_WORD: lmask = LMASK_W;
            WD_LONG: lmask = LMASK_L;
            WD_QUAD: lmask = LMASK_Q;
            default: lmask = LMASK_Q;
        endcase
    end

    assign amt  = AMT_W'(NBYTES) - AMT_W'(lane);
    assign kill = lmask >> amt;

    for (genvar k = 0; k < NBYTES; k++) begin : g_lane
        assign data_out[8*k +: 8] = kill[k] ? 8'h00 : data_in[8*k +: 8];
    end

endmodule

// File: rtl/bxm_high_unit.sv
module bxm_high_unit
    import bxm_pkg::*;
#(
    parameter int DATA_W = 64,
    localparam int NBYTES = DATA_W / 8,
    localparam int OFS_W  = $clog2(NBYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [FUNC_W-1:0] func,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic [DATA_W-1:0] dst_old,
    output logic              out_valid,
    output logic [DATA_W-1:0] result
);

    op_sel_t           sel;
    logic [OFS_W-1:0]  lane;
    logic [DATA_W-1:0] ins_val;
    logic [DATA_W-1:0] ext_val;
    logic [DATA_W-1:0] msk_val;
    logic [DATA_W-1:0] nxt_val;
    logic [DATA_W-1:0] res_q;
    logic              unused_b_hi;
    out_state_e        st_q;
    out_state_e        st_d;

    assign lane        = src_b[OFS_W-1:0];
    assign unused_b_hi = ^src_b[DATA_W-1:OFS_W];

    bxm_decode u_decode (
        .func (func),
        .sel  (sel)
    );

    bxm_hishift #(.DATA_W(DATA_W)) u_shift (
        .width   (sel.width),
        .data_in (src_a),
        .lane    (lane),
        .ins_out (ins_val),
        .ext_out (ext_val)
    );

    bxm_himask #(.DATA_W(DATA_W)) u_mask (
        .width    (sel.width),
        .data_in  (src_a),
        .lane     (lane),
        .data_out (msk_val)
    );

    always_comb begin
        unique case (sel.kind)
            OPK_INS:  nxt_val = ins_val;
            OPK_EXT:  nxt_val = ext_val;
            OPK_MSK:  nxt_val = msk_val;
            OPK_NONE: nxt_val = dst_old;
            default:  nxt_val = dst_old;
        endcase
    end

    // output sequencer: next-state logic
    always_comb begin
        unique case (st_q)
            OS_EMPTY: st_d = in_valid ? OS_FULL : OS_EMPTY;
            OS_FULL:  st_d = in_valid ? OS_FULL : OS_EMPTY;
            default:  st_d = OS_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) st_q <= OS_EMPTY;
        else     st_q <= st_d;
    end

    // result register
    always_ff @(posedge clk) begin
        if (rst)           res_q <= '0;
        else if (in_valid) res_q <= nxt_val;
    end

    assign out_valid = (st_q == OS_FULL);
    assign result    = res_q;

    assert_load_valid_R7: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_idle_valid_R7: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    assert_hold_result_R8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(result));

    assert_reset_clear_R9: assert property (@(posedge clk)
        rst |=> (result == '0 && !out_valid));

    assert_unknown_passes_old_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && sel.kind == OPK_NONE) |=> result == $past(dst_old));

    assert_mask_lane0_identity_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && sel.kind == OPK_MSK && lane == '0) |=> result == $past(src_a));

    assert_ext_word_zero_ext_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && sel.kind == OPK_EXT && sel.width == WD_WORD)
            |=> result[DATA_W-1:16] == '0);

endmodule

// File: tb/bxm_high_unit_tb.sv
module bxm_high_unit_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [6:0]  func;
    logic [63:0] src_a, src_b, dst_old;
    logic        out_valid;
    logic [63:0] result;

    int n_vec  = 0;
    int n_fail = 0;

    logic        exp_vld;
    logic [63:0] exp_res;
    string       exp_tag;
    bit          armed = 0;

    logic [6:0] codes [9] = '{7'h57, 7'h67, 7'h77, 7'h5A, 7'h6A, 7'h7A, 7'h52, 7'h62, 7'h72};

    always #(CLK_PERIOD/2) clk = ~clk;

    bxm_high_unit u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .func(func),
        .src_a(src_a), .src_b(src_b), .dst_old(dst_old),
        .out_valid(out_valid), .result(result)
    );

    function automatic logic [63:0] rnd64();
        return {$urandom, $urandom};
    endfunction

    function automatic string tag_of(logic [6:0] f);
        case (f[3:0])
            4'h7:    return "R1";
            4'hA:    return "R2";
            default: return "R3";
        endcase
    endfunction

    // bit-level reference, independent of any shifter structure
    function automatic logic [63:0] model(logic [6:0] f, logic [63:0] a, logic [63:0] b,
                                          logic [63:0] old);
        int ln   = int'(b[2:0]);
        int sh   = (64 - 8*ln) % 64;
        int nb;
        int kind;
        logic [63:0] r = '0;
        case (f)
            7'h57: begin kind = 1; nb = 2; end
            7'h67: begin kind = 1; nb = 4; end
            7'h77: begin kind = 1; nb = 8; end
            7'h5A: begin kind = 2; nb = 2; end
            7'h6A: begin kind = 2; nb = 4; end
            7'h7A: begin kind = 2; nb = 8; end
            7'h52: begin kind = 3; nb = 2; end
            7'h62: begin kind = 3; nb = 4; end
            7'h72: begin kind = 3; nb = 8; end
            default: return old;
        endcase
        if (kind == 1) begin
            for (int i = 0; i < 64; i++)
                if (i + sh < 8*nb) r[i] = a[i+sh];
        end else if (kind == 2) begin
            for (int i = 0; i < 64; i++)
                if (i < 8*nb && i >= sh) r[i] = a[i-sh];
        end else begin
            for (int k = 0; k < 8; k++)
                for (int j = 0; j < 8; j++)
                    r[8*k+j] = (k + 8 - ln < nb) ? 1'b0 : a[8*k+j];
        end
        return r;
    endfunction

    task automatic apply(input logic r, input logic v, input logic [6:0] f,
                         input logic [63:0] a, input logic [63:0] b,
                         input logic [63:0] o, input string tag);
        @(negedge clk);
        if (armed) begin
            n_vec++;
            if (out_valid !== exp_vld) begin
                n_fail++;
                $display("FAIL R7 (%s) out_valid: actual %0b expected %0b", exp_tag, out_valid, exp_vld);
            end
            if (result !== exp_res) begin
                n_fail++;
                $display("FAIL %s result: actual %h expected %h", exp_tag, result, exp_res);
            end
        end
        rst = r; in_valid = v; func = f; src_a = a; src_b = b; dst_old = o;
        if (r) begin
            exp_res = '0; exp_vld = 1'b0;
        end else if (v) begin
            exp_res = model(f, a, b, o); exp_vld = 1'b1;
        end else begin
            exp_vld = 1'b0;
        end
        exp_tag = tag;
        armed = 1;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin : main
        rst = 1; in_valid = 0; func = '0; src_a = '0; src_b = '0; dst_old = '0;

        // R9: strobe with live data during reset must lose to reset
        for (int i = 0; i < 3; i++)
            apply(1, 1, 7'h77, rnd64(), 64'(i), rnd64(), "R9");

        // R1 R2 R3: every code, every lane
        foreach (codes[c])
            for (int ln = 0; ln < 8; ln++)
                for (int k = 0; k < 4; k++)
                    apply(0, 1, codes[c], rnd64(), 64'(ln), rnd64(), tag_of(codes[c]));

        // R4: lane zero for every code, including all-ones source
        foreach (codes[c]) begin
            apply(0, 1, codes[c], rnd64(), 64'd0, rnd64(), "R4");
            apply(0, 1, codes[c], '1, 64'd0, rnd64(), "R4");
        end

        // R5: random upper bits of B
        for (int i = 0; i < 200; i++)
            apply(0, 1, codes[$urandom_range(8)], rnd64(), rnd64(), rnd64(), "R5");

        // R6: every unknown function code
        for (int f = 0; f < 128; f++) begin
            bit known = 0;
            foreach (codes[c]) if (codes[c] == 7'(f)) known = 1;
            if (!known) apply(0, 1, 7'(f), rnd64(), rnd64(), rnd64(), "R6");
        end

        // R8: load then idle with changing operands
        for (int i = 0; i < 20; i++) begin
            apply(0, 1, codes[$urandom_range(8)], rnd64(), rnd64(), rnd64(), "R7");
            for (int k = 0; k < 3; k++)
                apply(0, 0, codes[$urandom_range(8)], rnd64(), rnd64(), rnd64(), "R8");
        end

        // R7: back-to-back strobes
        for (int i = 0; i < 30; i++)
            apply(0, 1, codes[$urandom_range(8)], rnd64(), rnd64(), rnd64(), "R7");

        // R9: reset in mid-traffic with a strobe present
        apply(1, 1, 7'h7A, rnd64(), 64'd3, rnd64(), "R9");
        apply(0, 0, 7'h57, rnd64(), 64'd1, rnd64(), "R9");
        apply(0, 0, 7'h57, rnd64(), 64'd1, rnd64(), "R8");

        apply(0, 0, 7'h00, '0, '0, '0, "R8");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule